// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a small on-chip data store that a processor datapath uses for loads and stores. It holds a fixed number of 32-bit words and takes a 32-bit byte address. A 2-bit operation code selects one of four actions each cycle: a plain read, a single-byte store, a 16-bit store or a full-word store. Narrow stores merge their bytes into the stored word, and the bytes they do not address keep their values.

The read port is combinational. It always presents the whole aligned word that the address selects, whatever the operation code is. Stores take effect on the rising clock edge. A load unit that needs a narrow value therefore extracts its byte or halfword from the returned word. Only the address bits that index the array are decoded, so the higher address bits fold onto the same words.

Top module: `word_store`

## Requirements
- R1: While the active-low reset is sampled low at a rising edge, every word is cleared to zero, and any store presented in that cycle is discarded.
- R2: Operation code 00 is a read. `rdata` shows the word indexed by `addr[9:2]` combinationally, and the stored contents do not change.
- R3: Operation code 01 stores `wdata[7:0]` into byte lane `addr[1:0]` of the indexed word. Lanes are little-endian, so lane k is bits 8k+7..8k.
- R4: A byte or halfword store leaves every byte lane of the word that it does not address unchanged.
- R5: Operation code 10 stores `wdata[15:0]`. It goes into bits 15..0 when `addr[1]` is 0 and into bits 31..16 when `addr[1]` is 1, and `addr[0]` is ignored.
- R6: Operation code 11 replaces the whole indexed word with `wdata`, and `addr[1:0]` is ignored.
- R7: Address bits 31..10 have no effect, so addresses that differ only in those bits reach the same word.
- R8: A store commits at the rising edge. In the cycle the store is presented, `rdata` still shows the previous contents, and the new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of the array |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store data; narrow stores take the low bits |
| op | input | 2 | 00 read, 01 byte store, 10 halfword store, 11 word store |
| rdata | output | 32 | Aligned word at the addressed index |

## Verification
The read port is combinational, so a wrong lane enable or wrong merge data becomes visible as soon as the corrupted word is addressed again, one cycle after the faulty store at the earliest. A lane decode that picks the wrong byte shows up as two errors on the same word: a lost byte and a clobbered neighbour. Decoding the wrong index bits only shows up when an aliased or neighbouring address is read later. The reference model therefore compares the returned word on every cycle, and the stimulus returns to addresses it has written.

// File: rtl/word_store.sv
module word_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        op,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [1:0] OP_BYTE = 2'b01;
  localparam logic [1:0] OP_HALF = 2'b10;
  localparam logic [1:0] OP_WORD = 2'b11;

  logic [DATA_W-1:0]       mem [DEPTH];
  logic [IDX_W-1:0]        idx;
  logic [OFF_W-1:0]        off;
  logic [LANES-1:0]        lane_we;
  logic [LANES-1:0][7:0]   lane_d;
  logic                    unused_hi;

  assign idx       = addr[OFF_W +: IDX_W];
  assign off       = addr[OFF_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:OFF_W+IDX_W];
  assign rdata     = mem[idx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFF_W-1:0] LID = OFF_W'(l);
    assign lane_we[l] = (op == OP_WORD)
                      | (op == OP_HALF && off[OFF_W-1:1] == LID[OFF_W-1:1])
                      | (op == OP_BYTE && off == LID);
    assign lane_d[l]  = (op == OP_WORD) ? wdata[8*l +: 8]
                      : (op == OP_HALF) ? wdata[8*(l%2) +: 8]
                      : wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_we[l]) mem[idx][8*l +: 8] <= lane_d[l];
    end
  end
endmodule

// File: rtl/word_store_chk.sv
module word_store_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [1:0]        op,
  input logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              prev_valid;
  logic [1:0]        prev_op;
  logic [1:0]        prev_off;
  logic [IDX_W-1:0]  prev_idx;
  logic [DATA_W-1:0] prev_wdata, prev_rdata;
  logic              same;
  logic [DATA_W-1:0] mask_b, mask_h, sh_b, sh_h;

  always_ff @(posedge clk) begin
    prev_valid <= rst_n;
    prev_op    <= op;
    prev_off   <= addr[1:0];
    prev_idx   <= addr[2 +: IDX_W];
    prev_wdata <= wdata;
    prev_rdata <= rdata;
  end

  assign same   = prev_valid && (addr[2 +: IDX_W] == prev_idx);
  assign mask_b = {{(DATA_W-8){1'b0}}, 8'hFF}   << {prev_off, 3'b000};
  assign mask_h = {{(DATA_W-16){1'b0}}, 16'hFFFF} << {prev_off[1], 4'b0000};
  assign sh_b   = rdata >> {prev_off, 3'b000};
  assign sh_h   = rdata >> {prev_off[1], 4'b0000};

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> rdata == '0);
  p_read_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (same && prev_op == 2'b00) |-> rdata == prev_rdata);
  p_byte_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (same && prev_op == 2'b01) |-> sh_b[7:0] == prev_wdata[7:0]);
  p_byte_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (same && prev_op == 2'b01) |-> (rdata & ~mask_b) == (prev_rdata & ~mask_b));
  p_half_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (same && prev_op == 2'b10) |-> (rdata & ~mask_h) == (prev_rdata & ~mask_h));
  p_half_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (same && prev_op == 2'b10) |-> sh_h[15:0] == prev_wdata[15:0]);
  p_word_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (same && prev_op == 2'b11) |-> rdata == prev_wdata);
endmodule

bind word_store word_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_word_store.sv
`timescale 1ns/1ps
module tb_word_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  op = 2'b00;
  logic [31:0] rdata;

  logic [31:0] model [256];
  int vectors = 0;
  int miscompares = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  word_store dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .op(op), .rdata(rdata));

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check_now(input string tag);
    vectors++;
    if (rdata !== model[addr[9:2]]) begin
      miscompares++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, rdata, model[addr[9:2]]);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    op = o; addr = a; wdata = d;
    #1 check_now(tag);
    @(posedge clk);
    if (rst_n) begin
      case (o)
        2'b01: model[a[9:2]][8*a[1:0] +: 8] = d[7:0];
        2'b10: model[a[9:2]][16*a[1] +: 16] = d[15:0];
        2'b11: model[a[9:2]] = d;
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; op = 2'b11; addr = 32'h0000_0040; wdata = 32'hDEAD_BEEF;
    repeat (2) @(posedge clk);
    for (int w = 0; w < 256; w++) model[w] = '0;
    @(negedge clk);
    rst_n = 1'b1; op = 2'b00;
  endtask

  function automatic string tag_of(input logic [1:0] o);
    case (o)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    // R1: cleared after reset
    step(2'b00, 32'h0000_0000, '0, "R1");
    step(2'b00, 32'h0000_0040, '0, "R1");
    step(2'b00, 32'h0000_03FC, '0, "R1");
    step(2'b00, 32'h0000_0100, '0, "R1");

    // R6 word stores then R2 reads
    for (int i = 0; i < 16; i++) step(2'b11, 32'(i*4), 32'hA5A5_0000 + 32'(i), "R6");
    for (int i = 0; i < 16; i++) step(2'b00, 32'(i*4), '0, "R2");

    // R3 each byte lane, R4 neighbours kept
    step(2'b11, 32'h0000_0014, 32'h1122_3344, "R6");
    for (int l = 0; l < 4; l++) begin
      step(2'b01, 32'h0000_0014 + 32'(l), 32'hFFFF_FF00 + 32'(8'hC0 + l), "R3");
      step(2'b00, 32'h0000_0014, '0, "R4");
    end

    // R5 halfword at every offset, addr[0] ignored; R4 keeps other half
    for (int o = 0; o < 4; o++) begin
      step(2'b11, 32'h0000_0020, 32'h8899_AABB, "R6");
      step(2'b10, 32'h0000_0020 + 32'(o), 32'hEEEE_1357 + 32'(o), "R5");
      step(2'b00, 32'h0000_0020, '0, "R4");
    end

    // R6 misaligned word store
    step(2'b11, 32'h0000_0027, 32'hCAFE_F00D, "R6");
    step(2'b00, 32'h0000_0024, '0, "R6");

    // R7 aliasing through high address bits
    step(2'b11, 32'hABCD_0010, 32'h0BAD_CAFE, "R7");
    step(2'b00, 32'h0000_0010, '0, "R7");
    step(2'b01, 32'h0000_0412, 32'h0000_0077, "R7");
    step(2'b00, 32'hFFFF_FC10, '0, "R7");

    // R8 back-to-back stores: each cycle still shows old contents
    step(2'b11, 32'h0000_001C, 32'h1111_1111, "R8");
    step(2'b11, 32'h0000_001C, 32'h2222_2222, "R8");
    step(2'b01, 32'h0000_001D, 32'h0000_0033, "R8");
    step(2'b00, 32'h0000_001C, '0, "R8");

    // mixed random traffic over a small window so words are revisited
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  o;
      logic [31:0] a;
      seed = next_rand(seed);
      o = seed[1:0];
      a = {seed[31:22] ^ seed[21:12], 16'h0, seed[13:8]};
      seed = next_rand(seed);
      step(o, a, seed, tag_of(o));
    end

    // R1 reset in mid-run clears written words, store during reset dropped
    do_reset();
    step(2'b00, 32'h0000_0040, '0, "R1");
    step(2'b00, 32'h0000_0014, '0, "R1");
    step(2'b00, 32'h0000_0020, '0, "R1");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule